// File: doc/BRIEF.md
# Load Memory-Ordering Issue Gate

This block sits beside the issue selector of an out-of-order core and decides, for every reorder-buffer entry, whether that entry is allowed to issue. A load may be held back because an older store has not finished. The block combines that memory-ordering condition with the entry's register readiness. It produces one issue-permission bit per entry, registered once, which the selector then arbitrates over.

Three ordering policies can be chosen at run time. The first ignores memory dependences. The conservative policy makes a load wait for every older store. The exact policy makes a load wait only for older stores whose address is identical to its own. Accesses whose addresses overlap but differ are treated as independent.

Age is taken from sequence numbers that are one bit wider than the buffer index and wrap around. A store keeps blocking until it has both issued and completed execution.

Top module: `mem_dep_gate`

## Requirements
- R1: `issue_ok_o[i]` is a register. It reflects the inputs sampled at the previous rising clock edge, and it is all zero while `rst_ni` is low.
- R2: An entry with `valid_i[i]` low never gets `issue_ok_o[i]` set, and it never blocks another entry, whatever its flags.
- R3: `issue_ok_o[i]` is never set while `reg_ready_i[i]` is low, in any mode.
- R4: A valid entry with `load_i[i]` low and `reg_ready_i[i]` high always gets `issue_ok_o[i]` set, in any mode.
- R5: With `mode_i` = 0 (ignore), every valid, register-ready entry gets `issue_ok_o[i]` set.
- R6: With `mode_i` = 1, and also with the spare code 3 (conservative), a valid load is blocked if any other valid store that is older than it is not done.
- R7: With `mode_i` = 2 (exact), a valid load is blocked only by an older valid not-done store whose `addr_i` field is bit-for-bit equal to the load's own. Unequal addresses never block.
- R8: A store counts as done only when both `issued_i` and `exec_done_i` are high. Either flag alone leaves it blocking.
- R9: Entry A is older than entry B when the difference (seq_B - seq_A), taken modulo 2^SEQ_W and read as a signed number, is strictly positive. Younger stores, and stores with an equal sequence number, never block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 ignore, 1 conservative, 2 exact address, 3 conservative |
| valid_i | input | N_ENTRIES | Entry holds a micro-op |
| load_i | input | N_ENTRIES | Entry is a load |
| store_i | input | N_ENTRIES | Entry is a store |
| issued_i | input | N_ENTRIES | Entry has issued |
| exec_done_i | input | N_ENTRIES | Entry's completion cycle has been reached |
| reg_ready_i | input | N_ENTRIES | All source registers of entry are ready |
| seq_i | input | N_ENTRIES*SEQ_W | Packed wrapping sequence numbers, entry i at bits [i*SEQ_W +: SEQ_W] |
| addr_i | input | N_ENTRIES*ADDR_W | Packed access addresses, entry i at bits [i*ADDR_W +: ADDR_W] |
| issue_ok_o | output | N_ENTRIES | Registered per-entry issue permission |

## Verification
A wrong age comparison, a wrong done term or a wrong address match would release a load too early, or hold it too late. Either error shows on that entry's `issue_ok_o` bit one clock after the offending inputs are applied, because the block holds no other state. The bench compares every bit against a behavioural model on every cycle. It mixes random buffer contents with sequence numbers that straddle the wrap point and with a small address pool, so that equal and unequal addresses both occur often. Directed cases cover the half-done store states and the wrap boundary.

// File: rtl/mlg_pkg.sv
package mlg_pkg;
  typedef enum logic [1:0] {
    MODE_IGNORE  = 2'd0,
    MODE_CONSERV = 2'd1,
    MODE_EXACT   = 2'd2,
    MODE_SPARE   = 2'd3
  } dep_mode_e;
endpackage

// File: rtl/mlg_age_cmp.sv
module mlg_age_cmp #(
  parameter int SEQ_W = 4
) (
  input  logic [SEQ_W-1:0] seq_a_i,
  input  logic [SEQ_W-1:0] seq_b_i,
  output logic             a_older_o
);
  logic [SEQ_W-1:0] diff;

  // modular distance b - a, positive when read as signed
  assign diff      = seq_b_i - seq_a_i;
  assign a_older_o = (diff != '0) && !diff[SEQ_W-1];
endmodule

// File: rtl/mlg_entry_gate.sv
module mlg_entry_gate #(
  parameter int N      = 8,
  parameter int SEQ_W  = 4,
  parameter int ADDR_W = 16,
  parameter int IDX    = 0
) (
  input  mlg_pkg::dep_mode_e  mode_i,
  input  logic                self_load_i,
  input  logic [N-1:0]        valid_i,
  input  logic [N-1:0]        store_i,
  input  logic [N-1:0]        store_done_i,
  input  logic [N*SEQ_W-1:0]  seq_i,
  input  logic [N*ADDR_W-1:0] addr_i,
  output logic                mem_ok_o
);
  import mlg_pkg::*;

  logic [N-1:0] blk;

  for (genvar j = 0; j < N; j++) begin : g_pair
    if (j == IDX) begin : g_self
      assign blk[j] = 1'b0;
    end else begin : g_other
      logic older, addr_eq, cand;
      mlg_age_cmp #(.SEQ_W(SEQ_W)) u_age (
        .seq_a_i  (seq_i[j*SEQ_W +: SEQ_W]),
        .seq_b_i  (seq_i[IDX*SEQ_W +: SEQ_W]),
        .a_older_o(older)
      );
      assign addr_eq = addr_i[j*ADDR_W +: ADDR_W] == addr_i[IDX*ADDR_W +: ADDR_W];
      assign cand    = valid_i[j] && store_i[j] && !store_done_i[j] && older;
      always_comb begin
        unique case (mode_i)
          MODE_IGNORE: blk[j] = 1'b0;
          MODE_EXACT:  blk[j] = cand && addr_eq;
          default:     blk[j] = cand;
        endcase
      end
    end
  end

  assign mem_ok_o = !self_load_i || (mode_i == MODE_IGNORE) || (blk == '0);
endmodule

// File: rtl/mem_dep_gate.sv
module mem_dep_gate #(
  parameter int N_ENTRIES = 8,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = $clog2(N_ENTRIES),
  localparam int SEQ_W    = IDX_W + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [1:0]                    mode_i,
  input  logic [N_ENTRIES-1:0]          valid_i,
  input  logic [N_ENTRIES-1:0]          load_i,
  input  logic [N_ENTRIES-1:0]          store_i,
  input  logic [N_ENTRIES-1:0]          issued_i,
  input  logic [N_ENTRIES-1:0]          exec_done_i,
  input  logic [N_ENTRIES-1:0]          reg_ready_i,
  input  logic [N_ENTRIES*SEQ_W-1:0]    seq_i,
  input  logic [N_ENTRIES*ADDR_W-1:0]   addr_i,
  output logic [N_ENTRIES-1:0]          issue_ok_o
);
  import mlg_pkg::*;

  dep_mode_e              mode;
  logic [N_ENTRIES-1:0]   store_done;
  logic [N_ENTRIES-1:0]   mem_ok;
  logic [N_ENTRIES-1:0]   ok_d;

  assign mode       = dep_mode_e'(mode_i);
  assign store_done = issued_i & exec_done_i;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    mlg_entry_gate #(
      .N(N_ENTRIES), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .IDX(i)
    ) u_gate (
      .mode_i      (mode),
      .self_load_i (load_i[i]),
      .valid_i     (valid_i),
      .store_i     (store_i),
      .store_done_i(store_done),
      .seq_i       (seq_i),
      .addr_i      (addr_i),
      .mem_ok_o    (mem_ok[i])
    );
    assign ok_d[i] = valid_i[i] && reg_ready_i[i] && mem_ok[i];

    a_r2_invalid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i[i] |=> !issue_ok_o[i]);
    a_r3_reg_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !reg_ready_i[i] |=> !issue_ok_o[i]);
    a_r4_nonload_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[i] && reg_ready_i[i] && !load_i[i]) |=> issue_ok_o[i]);
    a_r5_ignore_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'd0 && valid_i[i] && reg_ready_i[i]) |=> issue_ok_o[i]);
    a_r6_no_store_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((valid_i & store_i) == '0 && valid_i[i] && reg_ready_i[i]) |=> issue_ok_o[i]);
    a_r8_all_done_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((valid_i & store_i & ~(issued_i & exec_done_i)) == '0 && valid_i[i] && reg_ready_i[i])
        |=> issue_ok_o[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) issue_ok_o <= '0;
    else         issue_ok_o <= ok_d;
  end

  a_r1_reset_clear: assert property (@(posedge clk_i) !rst_ni |=> issue_ok_o == '0);
endmodule

// File: tb/sim_mem_dep_gate.sv
module sim_mem_dep_gate;
  localparam int N      = 8;
  localparam int ADDR_W = 16;
  localparam int SEQ_W  = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] mode_i = '0;
  logic [N-1:0] valid_i = '0, load_i = '0, store_i = '0, issued_i = '0, exec_done_i = '0, reg_ready_i = '0;
  logic [N*SEQ_W-1:0] seq_i = '0;
  logic [N*ADDR_W-1:0] addr_i = '0;
  logic [N-1:0] issue_ok_o;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;

  mem_dep_gate #(.N_ENTRIES(N), .ADDR_W(ADDR_W)) u0 (.*);

  function automatic int seq_of(int k);
    return int'(seq_i[k*SEQ_W +: SEQ_W]);
  endfunction

  function automatic bit is_older(int a, int b);
    int d;
    d = (seq_of(b) - seq_of(a) + (1 << SEQ_W)) % (1 << SEQ_W);
    return d != 0 && d < (1 << (SEQ_W - 1));
  endfunction

  function automatic bit model(int i);
    if (!valid_i[i] || !reg_ready_i[i]) return 1'b0;
    if (!load_i[i] || mode_i == 2'd0) return 1'b1;
    for (int j = 0; j < N; j++) begin
      if (j != i && valid_i[j] && store_i[j] && !(issued_i[j] && exec_done_i[j]) && is_older(j, i)) begin
        if (mode_i != 2'd2) return 1'b0;
        if (addr_i[j*ADDR_W +: ADDR_W] == addr_i[i*ADDR_W +: ADDR_W]) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  function automatic string tag_of(int i);
    if (!valid_i[i]) return "R2";
    if (!reg_ready_i[i]) return "R3";
    if (!load_i[i]) return "R4";
    if (mode_i == 2'd0) return "R5";
    if (mode_i == 2'd2) return "R7";
    return "R6";
  endfunction

  // inputs held since last negedge; result due at this negedge
  task automatic step_check(string tag);
    bit [N-1:0] exp_v;
    for (int i = 0; i < N; i++) exp_v[i] = model(i);
    @(negedge clk_i);
    for (int i = 0; i < N; i++) begin
      checks++;
      if (issue_ok_o[i] !== exp_v[i]) begin
        errors++;
        $display("FAIL %s entry %0d: got %b expected %b", (tag == "") ? tag_of(i) : tag, i, issue_ok_o[i], exp_v[i]);
      end
    end
  endtask

  task automatic clear_all();
    valid_i = '0; load_i = '0; store_i = '0; issued_i = '0; exec_done_i = '0;
    reg_ready_i = '1; seq_i = '0; addr_i = '0;
  endtask

  task automatic set_op(int k, bit ld, bit st, int sq, int ad, bit iss, bit dn);
    valid_i[k] = 1'b1; load_i[k] = ld; store_i[k] = st;
    seq_i[k*SEQ_W +: SEQ_W] = SEQ_W'(sq); addr_i[k*ADDR_W +: ADDR_W] = ADDR_W'(ad);
    issued_i[k] = iss; exec_done_i[k] = dn;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    valid_i = '1; reg_ready_i = '1;
    repeat (3) @(negedge clk_i);
    checks++;
    if (issue_ok_o !== '0) begin
      errors++;
      $display("FAIL R1 reset: got %b expected %b", issue_ok_o, {N{1'b0}});
    end
    rst_ni = 1'b1;
    clear_all();

    // R8: half-done store states, conservative mode
    mode_i = 2'd1;
    set_op(0, 0, 1, 3, 16'h40, 1, 0); set_op(1, 1, 0, 4, 16'h40, 0, 0);
    step_check("R8");
    issued_i[0] = 0; exec_done_i[0] = 1; step_check("R8");
    issued_i[0] = 1; step_check("R8");

    // R9: wrap boundary, store seq 15 older than load seq 0
    clear_all(); mode_i = 2'd1;
    set_op(0, 0, 1, 15, 1, 0, 0); set_op(1, 1, 0, 0, 1, 0, 0);
    step_check("R9");
    seq_i[0 +: SEQ_W] = 4'd0; seq_i[SEQ_W +: SEQ_W] = 4'd15; step_check("R9");
    seq_i[0 +: SEQ_W] = 4'd7; seq_i[SEQ_W +: SEQ_W] = 4'd15; step_check("R9");

    // R7: exact mode, unequal then equal address
    clear_all(); mode_i = 2'd2;
    set_op(0, 0, 1, 2, 16'h100, 0, 0); set_op(1, 1, 0, 5, 16'h104, 0, 0);
    step_check("R7");
    addr_i[ADDR_W +: ADDR_W] = 16'h100; step_check("R7");
    mode_i = 2'd3; addr_i[ADDR_W +: ADDR_W] = 16'h104; step_check("R6");

    // R2: invalid older store does not block
    valid_i[0] = 0; step_check("R2");
    // R3: register wait dominates
    valid_i[0] = 1; mode_i = 2'd0; reg_ready_i[1] = 0; step_check("R3");

    // random buffers compared every cycle
    for (int t = 0; t < 3000; t++) begin
      int base;
      base = $urandom_range(0, 15);
      mode_i = 2'($urandom_range(0, 3));
      for (int k = 0; k < N; k++) begin
        valid_i[k] = ($urandom_range(0, 7) != 0);
        load_i[k] = $urandom_range(0, 1);
        store_i[k] = !load_i[k] && ($urandom_range(0, 2) != 0);
        issued_i[k] = $urandom_range(0, 1);
        exec_done_i[k] = $urandom_range(0, 1);
        reg_ready_i[k] = ($urandom_range(0, 4) != 0);
        seq_i[k*SEQ_W +: SEQ_W] = SEQ_W'((base + k) % 16);
        addr_i[k*ADDR_W +: ADDR_W] = ADDR_W'($urandom_range(0, 3) * 8);
      end
      step_check("");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule